// File: doc/BRIEF.md
# Modulo-N Clock Divider with Decoded Asynchronous Clear

The block divides an input clock by a fixed integer N. A free-running binary up-counter advances on every rising clock edge. A combinational terminal detector watches the count, and when the count reaches N the detector pulls an active-low clear that forces every counter flip-flop back to zero at once. State N therefore lasts only as long as the clear takes to propagate. Seen from one clock edge to the next, the counter steps through 0, 1, ..., N-1 and then repeats.

Two detector styles are built, and an input selects which one drives the clear. The full detector compares every counter bit with N. The reduced detector looks only at the bit positions that are 1 in N. The reduced detector is enough because, when the counter starts from zero, no earlier state in the sequence has all of those bits set together. When N is a power of two the counter wraps on its own and no detector is generated. The divided output is the counter's most significant bit. The external active-low reset is ANDed into the clear, so either source empties the counter.

Top module: `modN_divider`

## Requirements
- R1: On each rising clock edge with reset released, the count moves from k to k+1 for k < N-1, and from N-1 to 0.
- R2: Sampled between clock edges after reset, the count is always less than N.
- R3: With the decode select at 0 (full decode), the clear is low only when all counter bits equal N, and the sequence of R1 holds.
- R4: With the decode select at 1 (reduced decode: a NAND over the bit positions that are 1 in N), the sequence of R1 holds. In every reachable state the reduced and full detectors agree.
- R5: Driving the active-low reset to 0 clears the count to 0 at once, with no clock edge needed. It stays 0 while reset is held, and the first rising edge after release gives count 1.
- R6: The divided output equals bit W-1 of the count, and its period is exactly N input clock cycles (N=6 gives 6, N=5 gives 5, N=8 gives 8).
- R7: For N a power of two the counter wraps from N-1 to 0 with no clear (N=8 gives 0..7).
- R8: The default count width is the fewest bits that hold N, or log2(N) when N is a power of two: 3 bits for N=5, 6 and 8.
- R9: Changing the decode select while the counter runs does not disturb the count sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock to be divided |
| rstN | input | 1 | External asynchronous reset, active low |
| useReduced | input | 1 | 1 selects the reduced detector, 0 selects the full detector |
| count | output | W | Current counter value |
| divOut | output | 1 | Divided clock, the counter's top bit |

## Verification
The count changes on the rising edge, and the clear that follows state N acts within the same instant. So every count and divided-output value is due at the falling edge after the rising edge that caused it, and the bench drives and samples only at falling edges. A reset assertion takes effect without any clock, so the bench checks the count one nanosecond after pulling reset low. After release, the first count of 1 is expected at the first falling edge that follows a rising edge. The output period is measured in falling edges between two rises of the divided output.

// File: rtl/modN_divider_pkg.sv
package modN_divider_pkg;

  typedef struct packed {
    logic fullHitN;     // full detector output, low only at state N
    logic reducedHitN;  // reduced detector output
    logic clearN;       // combined active-low clear to the counter
  } divStrobes_t;

  function automatic bit isPow2(input int unsigned n);
    return (n != 0) && ((n & (n - 1)) == 0);
  endfunction

  function automatic int unsigned cntWidth(input int unsigned n);
    return isPow2(n) ? $clog2(n) : $clog2(n + 1);
  endfunction

endpackage

// File: rtl/modN_divider_ctrl.sv
module modN_divider_ctrl
  import modN_divider_pkg::*;
#(
  parameter int unsigned N = 6,
  parameter int unsigned W = 3
) (
  input  logic         rstN,
  input  logic         useReduced,
  input  logic [W-1:0] count,
  output divStrobes_t  strobes
);
  localparam bit NEED_CLEAR = !isPow2(N);
  localparam logic [W-1:0] TARGET = W'(N);

  logic fullHitN;
  logic reducedHitN;

  generate
    if (NEED_CLEAR) begin : g_detect
      // full word: bits that are 0 in N are inverted into the NAND
      assign fullHitN    = ~&(~(count ^ TARGET));
      // reduced: only the positions set in N feed the NAND
      assign reducedHitN = ~&(count | ~TARGET);
    end else begin : g_nodetect
      assign fullHitN    = 1'b1;
      assign reducedHitN = 1'b1;
    end
  endgenerate

  always_comb begin
    strobes.fullHitN    = fullHitN;
    strobes.reducedHitN = reducedHitN;
    strobes.clearN      = rstN & (useReduced ? reducedHitN : fullHitN);
  end

endmodule

// File: rtl/modN_divider_dp.sv
module modN_divider_dp
  import modN_divider_pkg::*;
#(
  parameter int unsigned W = 3
) (
  input  logic         clk,
  input  divStrobes_t  strobes,
  output logic [W-1:0] count,
  output logic         divOut
);
  logic clearN;
  assign clearN = strobes.clearN;

  always_ff @(posedge clk or negedge clearN) begin
    if (!clearN) count <= '0;
    else         count <= count + 1'b1;
  end

  assign divOut = count[W-1];

endmodule

// File: rtl/modN_divider.sv
module modN_divider
  import modN_divider_pkg::*;
#(
  parameter int unsigned N = 6,
  parameter int unsigned W = cntWidth(N)
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         useReduced,
  output logic [W-1:0] count,
  output logic         divOut
);
  divStrobes_t strobes;

  modN_divider_ctrl #(.N(N), .W(W)) u_ctrl (
    .rstN       (rstN),
    .useReduced (useReduced),
    .count      (count),
    .strobes    (strobes)
  );

  modN_divider_dp #(.W(W)) u_dp (
    .clk     (clk),
    .strobes (strobes),
    .count   (count),
    .divOut  (divOut)
  );

endmodule

// File: rtl/modN_divider_chk.sv
module modN_divider_chk
  import modN_divider_pkg::*;
#(
  parameter int unsigned N = 6,
  parameter int unsigned W = 3
) (
  input logic         clk,
  input logic         rstN,
  input logic [W-1:0] count,
  input logic         divOut,
  input divStrobes_t  strobes
);
  localparam logic [W-1:0] LAST = W'(N - 1);

  // R2: count seen at each edge stays below N
  p_below_n_r2: assert property (@(posedge clk) disable iff (!rstN)
    {1'b0, count} < (W + 1)'(N));

  // R1: one step per edge, N-1 returns to 0
  p_step_r1: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> count == (($past(count) == LAST) ? '0 : $past(count) + 1'b1));

  // R4: both detectors agree on every reachable state
  p_decoders_agree_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobes.fullHitN == strobes.reducedHitN);

  // R3: clear is inactive in every settled reachable state
  p_clear_idle_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobes.clearN);

  // R6: divided output follows the top count bit
  p_div_top_bit_r6: assert property (@(posedge clk) disable iff (!rstN)
    divOut == count[W-1]);

  // R5: count is empty while reset is held
  always @(negedge clk) begin
    if (!rstN) begin
      p_reset_zero_r5: assert (count == '0);
    end
  end

endmodule

bind modN_divider modN_divider_chk #(.N(N), .W(W)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .count   (count),
  .divOut  (divOut),
  .strobes (strobes)
);

// File: tb/modN_divider_bench.sv
`timescale 1ns/100ps
module modN_divider_bench;

  logic clk = 1'b0;
  logic rstN = 1'b1;
  logic useReduced = 1'b0;
  always #2.5 clk = ~clk;

  logic [2:0] cnt6, cnt8, cnt5;
  logic div6, div8, div5;

  modN_divider #(.N(6)) u_modN_divider (
    .clk(clk), .rstN(rstN), .useReduced(useReduced), .count(cnt6), .divOut(div6));
  modN_divider #(.N(8)) u_modN_divider_n8 (
    .clk(clk), .rstN(rstN), .useReduced(useReduced), .count(cnt8), .divOut(div8));
  modN_divider #(.N(5)) u_modN_divider_n5 (
    .clk(clk), .rstN(rstN), .useReduced(useReduced), .count(cnt5), .divOut(div5));

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // stimulus table: decode select per step, expected N=6 count after the edge
  localparam int STEPS = 18;
  localparam logic       SEL_T [STEPS] = '{0,0,0,0,0,0, 1,1,1,1,1,1, 0,1,0,1,0,1};
  localparam logic [2:0] EXP_T [STEPS] = '{1,2,3,4,5,0, 1,2,3,4,5,0, 1,2,3,4,5,0};

  function automatic logic pickDiv(input int idx);
    case (idx)
      0:       return div6;
      1:       return div8;
      default: return div5;
    endcase
  endfunction

  task automatic measurePeriod(input int idx, input int expN, input string req);
    logic prev;
    int   since = 0;
    int   rises = 0;
    int   guard = 0;
    @(negedge clk);
    prev = pickDiv(idx);
    while (rises < 3 && guard < 200) begin
      @(negedge clk);
      guard++;
      since++;
      if (pickDiv(idx) && !prev) begin
        if (rises > 0) check(req, since, expN);
        rises++;
        since = 0;
      end
      prev = pickDiv(idx);
    end
    if (rises < 3) check({req, " no edges"}, rises, 3);
  endtask

  initial begin
    #1 rstN = 1'b0;
    repeat (3) @(negedge clk);
    // R5: reset state
    check("R5 reset n6", cnt6, 0);
    check("R5 reset n8", cnt8, 0);
    check("R5 reset n5", cnt5, 0);
    // R8: width
    check("R8 width n6", $bits(cnt6), 3);
    rstN = 1'b1;

    // table walk: R1, R3, R4, R9, R6, R7, R2
    for (int k = 0; k < STEPS; k++) begin
      useReduced = SEL_T[k];
      @(negedge clk);
      check(SEL_T[k] ? "R4 reduced seq n6" : "R3 full seq n6", cnt6, EXP_T[k]);
      if (k >= 12) check("R9 select toggle n6", cnt6, EXP_T[k]);
      check("R6 top bit n6", div6, EXP_T[k][2]);
      check("R7 wrap n8", cnt8, (k + 1) % 8);
      check("R1 seq n5", cnt5, (k + 1) % 5);
      check("R2 below n5", int'(cnt5 < 3'd5), 1);
    end

    // R5: asynchronous reset mid-count, no clock edge needed
    @(negedge clk);
    #0.5 rstN = 1'b0;
    #1;
    check("R5 async clear n6", cnt6, 0);
    check("R5 async clear n5", cnt5, 0);
    @(negedge clk);
    @(negedge clk);
    check("R5 held n6", cnt6, 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R5 restart n6", cnt6, 1);
    check("R5 restart n8", cnt8, 1);

    // R6: output period in input cycles, both decode styles
    useReduced = 1'b0;
    measurePeriod(0, 6, "R6 period n6 full");
    measurePeriod(1, 8, "R6 period n8");
    measurePeriod(2, 5, "R6 period n5 full");
    useReduced = 1'b1;
    measurePeriod(0, 6, "R6 period n6 reduced");
    measurePeriod(2, 5, "R6 period n5 reduced");

    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 5000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) check("watchdog", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule